// File: doc/BRIEF.md
# Interrupt-capable GPIO controller

A general-purpose I/O block for up to 32 pins, configured through a simple word-addressed register read/write port. Each pin has an output value and an output-enable bit. Its input is brought into the clock domain by a two-stage synchroniser, and a per-line bypass bit shortens that path to one stage. The synchronised pin state can be read back at any time.

Every line can raise an interrupt in one of four senses. The sense is chosen by a polarity bit and an edge-select bit. A line takes part only while its enable bit is set. A one-byte routing entry sends the line to one of `NOUT` shared interrupt outputs, or to none. An output is the OR of all enabled, active lines routed to it. Level conditions hold an output high for as long as the condition lasts. A detected edge gives a one-cycle pulse.

The line count `NLINES` may be 1 to 32. Any other value builds 32 lines. The bus carries a word address: byte offset = 4 × word address.

Top module: `gpio_irq_ctrl`

## Requirements
- R1: After a synchronous reset, all of the following hold: output value, output enable, interrupt enable, polarity, edge-select and bypass registers read 0; every routing byte reads 0xFF; `irq_out` and `pin_oe` are 0.
- R2: The output value register (word 1, byte 0x04) drives `pin_out`, and the direction register (word 2, byte 0x08) drives `pin_oe`. The registers at words 1 to 6 read back what was written. A direction write is visible on `pin_oe` one cycle after the write edge.
- R3: Word 0 returns the pin input delayed by two clock edges. For a line whose bypass bit (word 6) is set, the delay is one edge.
- R4: With edge bit 0 (word 5), a line is active while its synchronised input is 1 if its polarity bit (word 4) is 1, and while the input is 0 if the polarity bit is 0. A level condition holds its output for as long as it persists.
- R5: With edge bit 1, polarity 1 detects a 0-to-1 change and polarity 0 detects a 1-to-0 change of the synchronised input. Each detected change drives its routed output for exactly one cycle.
- R6: A line whose interrupt-enable bit (word 3) is 0 never affects any `irq_out` bit.
- R7: The routing byte of line i lies at word 8 + i/4, in bits [31-8*(i%4) : 24-8*(i%4)], so line 0 is the most significant byte. A value below `NOUT` selects that output. Any other value leaves the line unrouted. Lines that share an output are ORed together.
- R8: Register bits at and above the line count read 0, and writes to them are ignored.
- R9: Reads of unused word addresses (word 7, routing words past the last line, words 16 and above) return 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_en | input | 1 | Register access strobe |
| bus_we | input | 1 | Write when 1, with bus_en |
| bus_addr | input | 6 | Word address |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for bus_addr (combinational) |
| pin_in | input | NL | Pin input levels |
| pin_out | output | NL | Pin output values |
| pin_oe | output | NL | Pin output enables |
| irq_out | output | NOUT | Shared interrupt outputs |

## Verification
The bench tries each of the four senses on its own line:
- Steady highs and lows separate the two level senses.
- Single 0-to-1 and 1-to-0 steps show that an edge gives a one-cycle pulse where a level would hold.

Routing is checked by placing two lines on one output and by giving other lines the "none" code and an out-of-range code. One line is then re-routed while active, which shows that the byte lane picks the output. Pin changes are read back one and two cycles later, with and without bypass, to separate the two input paths. A behavioural model is compared on every clock.

// File: rtl/gpio_irq_pkg.sv
package gpio_irq_pkg;
    localparam int          MAX_LINES   = 32;
    localparam logic [7:0]  ROUTE_NONE  = 8'hFF;
    localparam logic [2:0]  REGION_CTRL  = 3'b000;
    localparam logic [2:0]  REGION_ROUTE = 3'b001;
    localparam logic [2:0]  IDX_DATA = 3'd0;
    localparam logic [2:0]  IDX_DRV  = 3'd1;
    localparam logic [2:0]  IDX_OE   = 3'd2;
    localparam logic [2:0]  IDX_IEN  = 3'd3;
    localparam logic [2:0]  IDX_POL  = 3'd4;
    localparam logic [2:0]  IDX_EDG  = 3'd5;
    localparam logic [2:0]  IDX_BYP  = 3'd6;

    // {polarity, edge-select}
    typedef enum logic [1:0] {
        SENSE_LOW  = 2'b00,
        SENSE_FALL = 2'b01,
        SENSE_HIGH = 2'b10,
        SENSE_RISE = 2'b11
    } sense_e;

    function automatic int legal_lines(int n);
        return (n < 1 || n > MAX_LINES) ? MAX_LINES : n;
    endfunction

    function automatic logic line_active(sense_e s, logic cur, logic prev);
        case (s)
            SENSE_LOW:  return ~cur;
            SENSE_HIGH: return cur;
            SENSE_FALL: return prev & ~cur;
            default:    return cur & ~prev;
        endcase
    endfunction
endpackage

// File: rtl/gpio_sync.sv
module gpio_sync #(
    parameter int NL = 8
) (
    input  logic          clk,
    input  logic          rst,
    input  logic [NL-1:0] pin_in,
    input  logic [NL-1:0] byp,
    output logic [NL-1:0] cur,
    output logic [NL-1:0] prev
);
    logic [NL-1:0] stage1, stage2;

    always_ff @(posedge clk) begin
        if (rst) begin
            stage1 <= '0;
            stage2 <= '0;
            prev   <= '0;
        end else begin
            stage1 <= pin_in;
            stage2 <= stage1;
            prev   <= cur;
        end
    end

    assign cur = (byp & stage1) | (~byp & stage2);
endmodule

// File: rtl/gpio_regs.sv
module gpio_regs
    import gpio_irq_pkg::*;
#(
    parameter int NL = 8
) (
    input  logic            clk,
    input  logic            rst,
    input  logic            bus_en,
    input  logic            bus_we,
    input  logic [5:0]      bus_addr,
    input  logic [31:0]     bus_wdata,
    output logic [31:0]     bus_rdata,
    input  logic [NL-1:0]   din,
    output logic [NL-1:0]   drv_q,
    output logic [NL-1:0]   oe_q,
    output logic [NL-1:0]   ien_q,
    output logic [NL-1:0]   pol_q,
    output logic [NL-1:0]   edg_q,
    output logic [NL-1:0]   byp_q,
    output logic [NL*8-1:0] route_q
);
    logic [2:0] region, idx;
    logic       wr;
    assign region = bus_addr[5:3];
    assign idx    = bus_addr[2:0];
    assign wr     = bus_en && bus_we;

    always_ff @(posedge clk) begin
        if (rst) begin
            drv_q <= '0; oe_q <= '0; ien_q <= '0;
            pol_q <= '0; edg_q <= '0; byp_q <= '0;
            for (int i = 0; i < NL; i++) route_q[i*8 +: 8] <= ROUTE_NONE;
        end else if (wr && region == REGION_CTRL) begin
            case (idx)
                IDX_DRV: drv_q <= bus_wdata[NL-1:0];
                IDX_OE:  oe_q  <= bus_wdata[NL-1:0];
                IDX_IEN: ien_q <= bus_wdata[NL-1:0];
                IDX_POL: pol_q <= bus_wdata[NL-1:0];
                IDX_EDG: edg_q <= bus_wdata[NL-1:0];
                IDX_BYP: byp_q <= bus_wdata[NL-1:0];
                default: ;
            endcase
        end else if (wr && region == REGION_ROUTE) begin
            for (int i = 0; i < NL; i++)
                if (idx == 3'(i / 4))
                    route_q[i*8 +: 8] <= bus_wdata[31 - 8*(i % 4) -: 8];
        end
    end

    always_comb begin
        bus_rdata = '0;
        if (region == REGION_CTRL) begin
            case (idx)
                IDX_DATA: bus_rdata = 32'(din);
                IDX_DRV:  bus_rdata = 32'(drv_q);
                IDX_OE:   bus_rdata = 32'(oe_q);
                IDX_IEN:  bus_rdata = 32'(ien_q);
                IDX_POL:  bus_rdata = 32'(pol_q);
                IDX_EDG:  bus_rdata = 32'(edg_q);
                IDX_BYP:  bus_rdata = 32'(byp_q);
                default:  bus_rdata = '0;
            endcase
        end else if (region == REGION_ROUTE) begin
            for (int i = 0; i < NL; i++)
                if (idx == 3'(i / 4))
                    bus_rdata[31 - 8*(i % 4) -: 8] = route_q[i*8 +: 8];
        end
    end

    // R2
    dir_write_chk: assert property (@(posedge clk) disable iff (rst)
        (wr && bus_addr == {REGION_CTRL, IDX_OE}) |=> (oe_q == $past(bus_wdata[NL-1:0])));
endmodule

// File: rtl/gpio_irq_route.sv
module gpio_irq_route
    import gpio_irq_pkg::*;
#(
    parameter int NL   = 8,
    parameter int NOUT = 4
) (
    input  logic            clk,
    input  logic            rst,
    input  logic [NL-1:0]   cur,
    input  logic [NL-1:0]   prev,
    input  logic [NL-1:0]   ien,
    input  logic [NL-1:0]   pol,
    input  logic [NL-1:0]   edg,
    input  logic [NL*8-1:0] route,
    output logic [NOUT-1:0] irq_out
);
    logic [NL-1:0] act, routed, rise_v;

    always_comb begin
        for (int i = 0; i < NL; i++) begin
            act[i]    = ien[i] & line_active(sense_e'({pol[i], edg[i]}), cur[i], prev[i]);
            routed[i] = ({1'b0, route[i*8 +: 8]} < 9'(NOUT));
        end
    end

    for (genvar o = 0; o < NOUT; o++) begin : g_out
        logic hit;
        always_comb begin
            hit = 1'b0;
            for (int i = 0; i < NL; i++)
                if (act[i] && routed[i] && route[i*8 +: 8] == 8'(o)) hit = 1'b1;
        end
        assign irq_out[o] = hit;
    end

    assign rise_v = cur & ~prev;

    // R5
    edge_single_chk: assert property (@(posedge clk) disable iff (rst)
        ((rise_v & $past(rise_v)) == '0));
    // R7
    unrouted_quiet_chk: assert property (@(posedge clk) disable iff (rst)
        (routed == '0) |-> (irq_out == '0));
endmodule

// File: rtl/gpio_irq_ctrl.sv
module gpio_irq_ctrl
    import gpio_irq_pkg::*;
#(
    parameter  int NLINES = 8,
    parameter  int NOUT   = 4,
    localparam int NL     = legal_lines(NLINES)
) (
    input  logic            clk,
    input  logic            rst,
    input  logic            bus_en,
    input  logic            bus_we,
    input  logic [5:0]      bus_addr,
    input  logic [31:0]     bus_wdata,
    output logic [31:0]     bus_rdata,
    input  logic [NL-1:0]   pin_in,
    output logic [NL-1:0]   pin_out,
    output logic [NL-1:0]   pin_oe,
    output logic [NOUT-1:0] irq_out
);
    logic [NL-1:0]   cur, prev, ien, pol, edg, byp;
    logic [NL*8-1:0] route;

    gpio_sync #(.NL(NL)) u_sync (
        .clk(clk), .rst(rst), .pin_in(pin_in), .byp(byp), .cur(cur), .prev(prev)
    );

    gpio_regs #(.NL(NL)) u_regs (
        .clk(clk), .rst(rst), .bus_en(bus_en), .bus_we(bus_we),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .din(cur), .drv_q(pin_out), .oe_q(pin_oe), .ien_q(ien),
        .pol_q(pol), .edg_q(edg), .byp_q(byp), .route_q(route)
    );

    gpio_irq_route #(.NL(NL), .NOUT(NOUT)) u_route (
        .clk(clk), .rst(rst), .cur(cur), .prev(prev), .ien(ien),
        .pol(pol), .edg(edg), .route(route), .irq_out(irq_out)
    );

    // R1
    reset_quiet_chk: assert property (@(posedge clk) disable iff (rst)
        $past(rst) |-> (irq_out == '0 && pin_oe == '0));
    // R6
    masked_quiet_chk: assert property (@(posedge clk) disable iff (rst)
        (ien == '0) |-> (irq_out == '0));
endmodule

// File: tb/gpio_irq_ctrl_tb.sv
module gpio_irq_ctrl_tb;
    localparam int NL = 8;
    localparam int NO = 4;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          bus_en = 1'b0, bus_we = 1'b0;
    logic [5:0]    bus_addr = '0;
    logic [31:0]   bus_wdata = '0;
    logic [31:0]   bus_rdata;
    logic [NL-1:0] pin_in = '0;
    logic [NL-1:0] pin_out, pin_oe;
    logic [NO-1:0] irq_out;

    int n_checks = 0, n_fails = 0;
    bit done = 0;

    always #5 clk = ~clk;

    gpio_irq_ctrl #(.NLINES(NL), .NOUT(NO)) u_dut (
        .clk(clk), .rst(rst), .bus_en(bus_en), .bus_we(bus_we),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .pin_in(pin_in), .pin_out(pin_out), .pin_oe(pin_oe), .irq_out(irq_out)
    );

    // behavioural reference
    logic [NL-1:0] m_s1, m_s2, m_prev, m_out, m_dir, m_ien, m_pol, m_edg, m_byp;
    logic [7:0]    m_rt [NL];

    function automatic logic [NL-1:0] m_cur();
        logic [NL-1:0] c;
        for (int i = 0; i < NL; i++) c[i] = m_byp[i] ? m_s1[i] : m_s2[i];
        return c;
    endfunction

    function automatic logic [NO-1:0] m_irq();
        logic [NO-1:0] r = '0;
        logic [NL-1:0] c = m_cur();
        for (int i = 0; i < NL; i++) begin
            logic a;
            if (!m_edg[i]) a = m_pol[i] ? c[i] : !c[i];
            else           a = m_pol[i] ? (c[i] && !m_prev[i]) : (!c[i] && m_prev[i]);
            if (a && m_ien[i] && int'(m_rt[i]) < NO) r[m_rt[i]] = 1'b1;
        end
        return r;
    endfunction

    always @(posedge clk) begin
        if (rst) begin
            m_s1 <= '0; m_s2 <= '0; m_prev <= '0; m_out <= '0; m_dir <= '0;
            m_ien <= '0; m_pol <= '0; m_edg <= '0; m_byp <= '0;
            for (int i = 0; i < NL; i++) m_rt[i] <= 8'hFF;
        end else begin
            m_s1 <= pin_in; m_s2 <= m_s1; m_prev <= m_cur();
            if (bus_en && bus_we) begin
                case (bus_addr)
                    6'd1: m_out <= bus_wdata[NL-1:0];
                    6'd2: m_dir <= bus_wdata[NL-1:0];
                    6'd3: m_ien <= bus_wdata[NL-1:0];
                    6'd4: m_pol <= bus_wdata[NL-1:0];
                    6'd5: m_edg <= bus_wdata[NL-1:0];
                    6'd6: m_byp <= bus_wdata[NL-1:0];
                    6'd8, 6'd9:
                        for (int k = 0; k < 4; k++)
                            m_rt[(int'(bus_addr) - 8) * 4 + k] <= 8'(bus_wdata >> (24 - 8*k));
                    default: ;
                endcase
            end
        end
    end

    task automatic check(string tag, logic [31:0] act, logic [31:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fails++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    // per-cycle comparison against the model
    always @(negedge clk) begin
        if (!rst && !done) begin
            check("R7 per-cycle irq_out", 32'(irq_out), 32'(m_irq()));
            check("R2 per-cycle pin_out", 32'(pin_out), 32'(m_out));
            check("R2 per-cycle pin_oe",  32'(pin_oe),  32'(m_dir));
        end
    end

    task automatic wr(logic [5:0] a, logic [31:0] d);
        @(posedge clk); #1;
        bus_en = 1; bus_we = 1; bus_addr = a; bus_wdata = d;
        @(posedge clk); #1;
        bus_en = 0; bus_we = 0;
    endtask

    task automatic rd(logic [5:0] a, logic [31:0] exp, string tag);
        @(posedge clk); #1;
        bus_addr = a;
        #3 check(tag, bus_rdata, exp);
    endtask

    task automatic set_pins(logic [NL-1:0] v);
        @(posedge clk); #1 pin_in = v;
    endtask

    task automatic irq_after(int n, logic [NO-1:0] exp, string tag);
        repeat (n) @(posedge clk);
        @(negedge clk);
        check(tag, 32'(irq_out), 32'(exp));
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            done = 1;
            n_checks++; n_fails++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
            $finish;
        end
    end

    initial begin
        repeat (3) @(posedge clk);
        #1 rst = 0;
        // R1 reset state
        rd(6'd1, 32'h0, "R1 drv reset");
        rd(6'd2, 32'h0, "R1 dir reset");
        rd(6'd3, 32'h0, "R1 ien reset");
        rd(6'd4, 32'h0, "R1 pol reset");
        rd(6'd5, 32'h0, "R1 edg reset");
        rd(6'd6, 32'h0, "R1 byp reset");
        rd(6'd8, 32'hFFFF_FFFF, "R1 route0 reset");
        rd(6'd9, 32'hFFFF_FFFF, "R1 route1 reset");
        check("R1 irq reset", 32'(irq_out), 32'h0);
        check("R1 oe reset", 32'(pin_oe), 32'h0);
        // R9 unused words
        rd(6'd7,  32'h0, "R9 word7");
        rd(6'd10, 32'h0, "R9 route word past lines");
        rd(6'd16, 32'h0, "R9 high word");
        // R8 upper bits
        wr(6'd3, 32'hFFFF_FFFF);
        rd(6'd3, 32'h0000_00FF, "R8 ien upper bits");
        wr(6'd3, 32'h0);
        // R2 outputs
        wr(6'd1, 32'hA5);
        wr(6'd2, 32'h0F);
        rd(6'd1, 32'hA5, "R2 drv readback");
        rd(6'd2, 32'h0F, "R2 dir readback");
        check("R2 pin_out", 32'(pin_out), 32'hA5);
        check("R2 pin_oe", 32'(pin_oe), 32'h0F);
        wr(6'd4, 32'h5A);
        rd(6'd4, 32'h5A, "R2 pol readback");
        wr(6'd4, 32'h0);
        // R3 synchroniser depth and bypass
        set_pins(8'h3C);
        rd(6'd0, 32'h00, "R3 data after one edge");
        rd(6'd0, 32'h3C, "R3 data after two edges");
        wr(6'd6, 32'h01);
        set_pins(8'h3D);
        rd(6'd0, 32'h3D, "R3 bypass line after one edge");
        wr(6'd6, 32'h0);
        set_pins(8'h00);
        // R7 routing bytes: l0->1 l1->2 l2->none l3->1 | l4->3 l5->0 l6->7 l7->none
        wr(6'd8, 32'h0102_FF01);
        wr(6'd9, 32'h0300_07FF);
        rd(6'd8, 32'h0102_FF01, "R7 route word readback");
        // R4 active-high level on line 0
        wr(6'd4, 32'h01);
        wr(6'd3, 32'h01);
        irq_after(1, 4'b0000, "R4 high level idle");
        set_pins(8'h01);
        irq_after(3, 4'b0010, "R4 high level active");
        irq_after(4, 4'b0010, "R4 high level held");
        set_pins(8'h00);
        irq_after(3, 4'b0000, "R4 high level released");
        // R4 active-low level on line 3
        wr(6'd4, 32'h00);
        wr(6'd3, 32'h08);
        irq_after(1, 4'b0010, "R4 low level active");
        set_pins(8'h08);
        irq_after(3, 4'b0000, "R4 low level released");
        // R7 shared output: lines 0 and 3 on output 1
        wr(6'd4, 32'h01);
        wr(6'd3, 32'h09);
        set_pins(8'h01);
        irq_after(3, 4'b0010, "R7 shared output");
        // R7 unrouted lines 2 (0xFF) and 6 (7 >= NOUT)
        wr(6'd3, 32'h00);
        wr(6'd4, 32'h44);
        set_pins(8'h44);
        wr(6'd3, 32'h44);
        irq_after(2, 4'b0000, "R7 unrouted lines quiet");
        wr(6'd8, 32'h0102_0201);
        irq_after(1, 4'b0100, "R7 line2 rerouted to out2");
        // R6 enable cleared
        wr(6'd3, 32'h00);
        irq_after(3, 4'b0000, "R6 disabled lines quiet");
        // R5 rising edge on line 4 -> out 3
        set_pins(8'h00);
        wr(6'd4, 32'h10);
        wr(6'd5, 32'h10);
        wr(6'd3, 32'h10);
        irq_after(2, 4'b0000, "R5 rising idle");
        set_pins(8'h10);
        irq_after(2, 4'b1000, "R5 rising pulse");
        irq_after(0, 4'b0000, "R5 rising pulse one cycle");
        irq_after(3, 4'b0000, "R5 rising no hold");
        // R5 falling edge on line 5 -> out 0
        wr(6'd3, 32'h00);
        wr(6'd4, 32'h00);
        wr(6'd5, 32'h20);
        set_pins(8'h20);
        wr(6'd3, 32'h20);
        irq_after(2, 4'b0000, "R5 falling ignores rise");
        set_pins(8'h00);
        irq_after(2, 4'b0001, "R5 falling pulse");
        irq_after(0, 4'b0000, "R5 falling pulse one cycle");
        repeat (3) @(posedge clk);
        @(negedge clk);
        done = 1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
        $finish;
    end
endmodule